// File: doc/BRIEF.md
# Segmented Kernel Address Translator

This block turns a 32-bit virtual address into a physical address. The address space is split into sixteen 256 MB regions, and the top four address bits pick the region. Each region has its own mode bit. A region in direct mode keeps the low 28 address bits and puts a programmable 4-bit physical base in place of the top nibble. A region in paged mode is not translated here. The request is passed on unchanged, with a pulse that asks the page-walk logic to resolve it.

Every request carries a privilege flag. In user mode only the lower eleven regions (0x00000000 to 0xAFFFFFFF) may be used, and any other access is reported as a fault. In kernel mode all sixteen regions can be reached, so kernel and user mappings live in one map. A small write port loads the mode word and the two base words. A unity setting (a region's base equal to its own index) lets translation be turned on under code that is already running, without moving that code.

Top module: `kseg_translator`

## Requirements
- R1: After reset no result pulse is high, every region is in paged mode and every base is zero, so a kernel request to any region produces a walk pulse.
- R2: A request to a direct-mode region that is allowed for its privilege gives `rsp_phys` one cycle later. `rsp_addr` is then the region's 4-bit base followed by virtual bits 27:0 (region 0xC with base 0x4 maps 0xC0000000 to 0x40000000).
- R3: A request to a paged-mode region that is allowed for its privilege gives `rsp_walk` one cycle later, with `rsp_addr` equal to the virtual address.
- R4: A user request (`req_user`=1) to regions 0xB through 0xF gives `rsp_fault` one cycle later, whatever that region's mode is, with `rsp_addr` equal to the virtual address. A user request to 0xAFFFFFFF is not a fault.
- R5: Kernel requests (`req_user`=0) never fault, including in regions 0xB to 0xF.
- R6: Each accepted request produces exactly one of `rsp_phys`, `rsp_walk`, `rsp_fault`, high for one cycle. A cycle without a request leaves all three low in the cycle that follows.
- R7: Writes with `cfg_sel`=0 load the mode word: bit i set selects direct mode for region i and clear selects paged mode. Writes with `cfg_sel`=1 load the bases of regions 0..7, and writes with `cfg_sel`=2 load the bases of regions 8..15. Region k takes its base from data bits 4(k mod 8)+3 down to 4(k mod 8) of its own word.
- R8: A configuration write applies to requests made in later cycles. A request in the same cycle as a write is translated with the configuration from before that write.
- R9: A write with `cfg_sel`=3 changes no mode and no base.
- R10: A direct-mode region whose base equals its index returns the virtual address unchanged as the physical address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Word select: 0 mode, 1 low bases, 2 high bases, 3 none |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Translation request strobe |
| req_user | input | 1 | 1 = user privilege, 0 = kernel |
| req_vaddr | input | 32 | Virtual address |
| rsp_phys | output | 1 | Pulse: translated physical address on `rsp_addr` |
| rsp_walk | output | 1 | Pulse: page walk needed, virtual address on `rsp_addr` |
| rsp_fault | output | 1 | Pulse: user access out of range, virtual address on `rsp_addr` |
| rsp_addr | output | 32 | Result address for the current pulse |

## Verification
A request driven in one cycle has its result pulse and address due in the cycle right after, and the next cycle must be quiet unless a new request came in. The bench drives on falling edges and reads the result on the falling edge after the sampling rising edge, so each read lands in the one cycle where the result is due. A configuration write is only expected to affect requests driven after its own cycle. The bench updates its model when the write completes, and one directed case puts a write and a request in the same cycle to confirm that the old setting is still used.

// File: rtl/kseg_pkg.sv
package kseg_pkg;

   typedef enum logic [1:0] {
      CFG_MODE    = 2'd0,
      CFG_BASE_LO = 2'd1,
      CFG_BASE_HI = 2'd2,
      CFG_NONE    = 2'd3
   } cfg_sel_e;

   typedef enum logic [1:0] {
      RES_NONE  = 2'd0,
      RES_PHYS  = 2'd1,
      RES_WALK  = 2'd2,
      RES_FAULT = 2'd3
   } res_e;

endpackage

// File: rtl/kseg_cfg_regs.sv
module kseg_cfg_regs
   import kseg_pkg::*;
#(
   parameter int NUM_SEG = 16,
   parameter int BASE_W  = 4,
   parameter int CFG_W   = 32
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             we,
   input  logic [1:0]                       sel,
   input  logic [CFG_W-1:0]                 wdata,
   output logic [NUM_SEG-1:0]               mode_o,
   output logic [NUM_SEG-1:0][BASE_W-1:0]   base_o
);
   localparam int HALF = NUM_SEG / 2;

   if (NUM_SEG % 2 != 0) begin : g_bad_even
      $error("kseg_cfg_regs: NUM_SEG must be even");
   end
   if (HALF * BASE_W > CFG_W) begin : g_bad_base
      $error("kseg_cfg_regs: half of the bases must fit one word");
   end
   if (NUM_SEG > CFG_W) begin : g_bad_mode
      $error("kseg_cfg_regs: mode word wider than data");
   end

   logic [NUM_SEG-1:0] mode_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         mode_q <= '0;
      else if (we && sel == CFG_MODE)
         mode_q <= wdata[NUM_SEG-1:0];
   end
   assign mode_o = mode_q;

   for (genvar i = 0; i < NUM_SEG; i++) begin : g_seg
      localparam int       SLOT = i % HALF;
      localparam cfg_sel_e BANK = (i < HALF) ? CFG_BASE_LO : CFG_BASE_HI;
      logic [BASE_W-1:0] base_q;

      always_ff @(posedge clk) begin
         if (!rst_n)
            base_q <= '0;
         else if (we && sel == BANK)
            base_q <= wdata[SLOT*BASE_W +: BASE_W];
      end
      assign base_o[i] = base_q;
   end

   // R9
   reserved_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && sel == CFG_NONE) |=> ($stable(mode_o) && $stable(base_o)));

   // R7
   mode_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && sel == CFG_MODE) |=> (mode_o == $past(wdata[NUM_SEG-1:0])));

endmodule

// File: rtl/kseg_lookup.sv
module kseg_lookup
   import kseg_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int SEG_W     = 4,
   parameter int USER_SEGS = 11
) (
   input  logic                                  user,
   input  logic [ADDR_W-1:0]                     vaddr,
   input  logic [(1<<SEG_W)-1:0]                 mode,
   input  logic [(1<<SEG_W)-1:0][SEG_W-1:0]      base,
   output res_e                                  res,
   output logic [ADDR_W-1:0]                     addr
);
   localparam int NUM_SEG = 1 << SEG_W;
   localparam int OFF_W   = ADDR_W - SEG_W;

   if (USER_SEGS < 1 || USER_SEGS > NUM_SEG) begin : g_bad_user
      $error("kseg_lookup: USER_SEGS out of range");
   end

   logic [SEG_W-1:0] seg;
   logic             user_ok;

   assign seg = vaddr[ADDR_W-1 -: SEG_W];

   if (USER_SEGS == NUM_SEG) begin : g_no_fence
      assign user_ok = 1'b1;
   end else begin : g_fence
      localparam logic [SEG_W:0] LIM = USER_SEGS[SEG_W:0];
      assign user_ok = ({1'b0, seg} < LIM);
   end

   always_comb begin
      if (user && !user_ok) begin
         res  = RES_FAULT;
         addr = vaddr;
      end else if (mode[seg]) begin
         res  = RES_PHYS;
         addr = {base[seg], vaddr[OFF_W-1:0]};
      end else begin
         res  = RES_WALK;
         addr = vaddr;
      end
   end

endmodule

// File: rtl/kseg_translator.sv
module kseg_translator
   import kseg_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int SEG_W     = 4,
   parameter int USER_SEGS = 11,
   parameter int CFG_W     = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_sel,
   input  logic [CFG_W-1:0]  cfg_wdata,
   input  logic              req_valid,
   input  logic              req_user,
   input  logic [ADDR_W-1:0] req_vaddr,
   output logic              rsp_phys,
   output logic              rsp_walk,
   output logic              rsp_fault,
   output logic [ADDR_W-1:0] rsp_addr
);
   localparam int NUM_SEG = 1 << SEG_W;
   localparam int OFF_W   = ADDR_W - SEG_W;
   localparam logic [SEG_W:0] USER_LIM = USER_SEGS[SEG_W:0];

   if (ADDR_W <= SEG_W) begin : g_bad_addr
      $error("kseg_translator: ADDR_W must exceed SEG_W");
   end

   logic [NUM_SEG-1:0]             mode;
   logic [NUM_SEG-1:0][SEG_W-1:0]  base;
   res_e                           res_d;
   res_e                           res_q;
   logic [ADDR_W-1:0]              addr_d;
   logic [ADDR_W-1:0]              addr_q;

   kseg_cfg_regs #(
      .NUM_SEG (NUM_SEG),
      .BASE_W  (SEG_W),
      .CFG_W   (CFG_W)
   ) u_cfg (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (cfg_we),
      .sel    (cfg_sel),
      .wdata  (cfg_wdata),
      .mode_o (mode),
      .base_o (base)
   );

   kseg_lookup #(
      .ADDR_W    (ADDR_W),
      .SEG_W     (SEG_W),
      .USER_SEGS (USER_SEGS)
   ) u_lookup (
      .user  (req_user),
      .vaddr (req_vaddr),
      .mode  (mode),
      .base  (base),
      .res   (res_d),
      .addr  (addr_d)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_q  <= RES_NONE;
         addr_q <= '0;
      end else begin
         res_q <= req_valid ? res_d : RES_NONE;
         if (req_valid)
            addr_q <= addr_d;
      end
   end

   assign rsp_phys  = (res_q == RES_PHYS);
   assign rsp_walk  = (res_q == RES_WALK);
   assign rsp_fault = (res_q == RES_FAULT);
   assign rsp_addr  = addr_q;

   // R6
   one_result_per_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> ($countones({rsp_phys, rsp_walk, rsp_fault}) == 1));

   // R6
   quiet_without_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !(rsp_phys || rsp_walk || rsp_fault));

   // R4
   user_fence_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_user && ({1'b0, req_vaddr[ADDR_W-1 -: SEG_W]} >= USER_LIM))
      |=> rsp_fault);

   // R5
   kernel_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_user) |=> !rsp_fault);

   // R2
   offset_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (rsp_addr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0])));

   // R3
   untranslated_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (rsp_phys || rsp_addr == $past(req_vaddr)));

endmodule

// File: tb/kseg_translator_test.sv
module kseg_translator_test;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cfg_we;
   logic [1:0]  cfg_sel;
   logic [31:0] cfg_wdata;
   logic        req_valid;
   logic        req_user;
   logic [31:0] req_vaddr;
   logic        rsp_phys;
   logic        rsp_walk;
   logic        rsp_fault;
   logic [31:0] rsp_addr;

   int checks   = 0;
   int failures = 0;
   bit done     = 0;

   logic [15:0] mode_m;
   logic [3:0]  base_m [16];

   always #2 clk = ~clk;

   kseg_translator uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_sel   (cfg_sel),
      .cfg_wdata (cfg_wdata),
      .req_valid (req_valid),
      .req_user  (req_user),
      .req_vaddr (req_vaddr),
      .rsp_phys  (rsp_phys),
      .rsp_walk  (rsp_walk),
      .rsp_fault (rsp_fault),
      .rsp_addr  (rsp_addr)
   );

   // code: 1 phys, 2 walk, 3 fault, 0 none
   function automatic logic [33:0] expect_rsp(input logic user, input logic [31:0] va);
      logic [3:0] s;
      s = va[31:28];
      if (user && s >= 4'hB) return {2'd3, va};
      if (mode_m[s])         return {2'd1, base_m[s], va[27:0]};
      return {2'd2, va};
   endfunction

   function automatic logic [1:0] seen_code();
      if (rsp_phys)  return 2'd1;
      if (rsp_walk)  return 2'd2;
      if (rsp_fault) return 2'd3;
      return 2'd0;
   endfunction

   function automatic string tag_of(input logic [1:0] c, input logic user);
      if (c == 2'd1) return "R2";
      if (c == 2'd2) return "R3";
      if (c == 2'd3) return "R4";
      return user ? "R6" : "R5";
   endfunction

   task automatic check(input string req, input logic [33:0] act, input logic [33:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic model_write(input logic [1:0] sel, input logic [31:0] d);
      case (sel)
         2'd0: mode_m = d[15:0];
         2'd1: for (int k = 0; k < 8; k++) base_m[k]     = d[4*k +: 4];
         2'd2: for (int k = 0; k < 8; k++) base_m[k + 8] = d[4*k +: 4];
         default: ;
      endcase
   endtask

   task automatic cfg_write(input logic [1:0] sel, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
      model_write(sel, d);
   endtask

   // drives one request, checks the result in the cycle after
   task automatic request(input logic user, input logic [31:0] va, input string tag);
      logic [33:0] e;
      @(negedge clk);
      req_valid = 1'b1; req_user = user; req_vaddr = va;
      e = expect_rsp(user, va);
      @(negedge clk);
      req_valid = 1'b0;
      check(tag, {seen_code(), rsp_addr}, e);
      check("R6", 34'(int'(rsp_phys) + int'(rsp_walk) + int'(rsp_fault)), 34'd1);
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [33:0] e;
      void'($urandom(32'd2024));
      rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
      req_valid = 1'b0; req_user = 1'b0; req_vaddr = '0;
      mode_m = '0;
      for (int k = 0; k < 16; k++) base_m[k] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: quiet outputs, paged everywhere
      check("R1", {32'd0, rsp_phys, rsp_walk}, {32'd0, 1'b0, 1'b0});
      check("R1", {33'd0, rsp_fault}, 34'd0);
      request(1'b0, 32'hC000_1234, "R1");
      request(1'b0, 32'hF000_0000, "R1");

      // R7: bases for regions B, C, E in the high word; modes for B,C,E,F
      cfg_write(2'd2, 32'h0804_B000);
      cfg_write(2'd0, 32'h0000_D800);
      request(1'b0, 32'hC000_0000, "R7");
      request(1'b0, 32'hC123_4567, "R2");
      request(1'b0, 32'hB000_0010, "R5");
      request(1'b0, 32'hEFFF_FFFF, "R5");
      request(1'b0, 32'hF000_0004, "R5");
      request(1'b0, 32'hD000_0000, "R3");

      // R4 boundary and mode independence
      request(1'b1, 32'hAFFF_FFFF, "R4");
      request(1'b1, 32'hB000_0000, "R4");
      request(1'b1, 32'hC000_0000, "R4");
      request(1'b1, 32'hD004_000C, "R4");

      // R10: unity mapping of region 4 via the low word
      cfg_write(2'd1, 32'h0004_0000);
      cfg_write(2'd0, 32'h0000_D810);
      request(1'b0, 32'h4123_4567, "R10");
      request(1'b1, 32'h4000_0000, "R10");

      // R9: reserved select leaves everything alone
      cfg_write(2'd3, 32'hFFFF_FFFF);
      request(1'b0, 32'hC000_0000, "R9");
      request(1'b0, 32'h2000_0000, "R9");
      request(1'b0, 32'h4000_0008, "R9");

      // R8: write and request in the same cycle use the old setting
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = 2'd2; cfg_wdata = 32'h0007_0000;
      req_valid = 1'b1; req_user = 1'b0; req_vaddr = 32'hC000_0100;
      e = expect_rsp(1'b0, 32'hC000_0100);
      @(negedge clk);
      cfg_we = 1'b0; req_valid = 1'b0;
      check("R8", {seen_code(), rsp_addr}, e);
      model_write(2'd2, 32'h0007_0000);
      request(1'b0, 32'hC000_0100, "R8");

      // R6: idle cycle after a request is quiet
      @(negedge clk);
      check("R6", {31'd0, rsp_phys, rsp_walk, rsp_fault}, 34'd0);

      // random mix
      for (int n = 0; n < 400; n++) begin
         logic [31:0] va;
         logic        u;
         if (($urandom % 5) == 0)
            cfg_write(2'($urandom % 4), $urandom);
         va = $urandom;
         u  = 1'($urandom);
         request(u, va, tag_of(expect_rsp(u, va) >> 32, u));
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule